// File: doc/BRIEF.md
# Quad 8-bit DAC Serial Control Front End

This block is the digital side of a four-channel, 8-bit digital-to-analog converter. A host frames a 12-bit command with an active-low select line and clocks it in, most significant bit first, on a slow serial clock. Each command carries two active-low power-down bits, a 2-bit channel number and one 8-bit code. When the select line rises after exactly twelve serial clocks, the code goes into that channel's staging (input) register. Commands with any other clock count are dropped.

The staged codes reach the four output code registers only while an active-low transfer level is held low. All four channels move together. An active-low zero input forces every staging and output register to 0x00 and wins over any other update. Power-down state is reported as one flag per channel. The stored code is kept while a channel is powered down.

All five host inputs are asynchronous. Each one passes through a two-flop synchroniser into the system clock domain, and its edges are detected there. The serial clock must therefore run at no more than a quarter of the system clock rate.

Top module: `qdac_front`

## Requirements
- R1: After a synchronous active-low reset, all four output codes are 0x00 and all four power-down flags are 0.
- R2: A command is 12 bits, sent most significant bit first. Bit 11 is the all-channel power-down (0 = power down). Bit 10 is the single-channel power-down (0 = power down). Bits 9:8 are the channel number. Bits 7:0 are the code. One bit is taken on each serial clock rise while select is low. Serial clock rises while select is high have no effect.
- R3: When select rises after exactly 12 serial clocks, the staging register of channel 0, 1, 2 or 3 is loaded with the code. The channel is picked by bits 9:8 = 00, 01, 10 or 11.
- R4: When select rises after any count other than 12, the command is dropped. No code and no flag changes.
- R5: While the transfer input is low, every output code takes the value of its staging register. While it is high, the output codes hold their values.
- R6: While the zero input is low, all staging and output registers are 0x00. This wins over a command and over a transfer in the same cycle, and the zero value stays after zero rises.
- R7: A command with bit 11 = 0 sets all four flags. A later command with bit 11 = 1 removes this global power-down.
- R8: A command with bit 10 = 0 sets the flag of its own channel. A later command to that channel with bits 11 and 10 both 1 clears it.
- R9: Powering a channel down does not alter its stored code, and its flag does not depend on the transfer or zero inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_sys | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| frame_n | input | 1 | Active-low command select (async) |
| bit_clk | input | 1 | Serial bit clock (async) |
| bit_in | input | 1 | Serial data (async) |
| xfer_n | input | 1 | Active-low level transfer to outputs (async) |
| zero_n | input | 1 | Active-low clear of all code registers (async) |
| dac_code | output | 32 | Four packed 8-bit output codes, channel 0 in bits 7:0 |
| chan_off | output | 4 | Per-channel power-down flags |

## Verification
A vector table sends one command to each channel number. These commands set the ones and zeros of all eight code bits in different places, so a swapped channel number or a reversed bit order shows up. Power-down commands follow in order: single-channel, then global, then release. These tell apart a global flag that is merged with the per-channel flags from one that overwrites them. Commands of 11 and 13 clocks check that the count must be exactly twelve. Directed cases then hold transfer high, toggle the serial clock with select high, and hold zero low across a command and a transfer. Each of these shows whether the input acted or was ignored.

// File: rtl/qdac_pkg.sv
// Package: field positions of the serial command word, derived from widths.
// Assumes: word = {global_off_n, single_off_n, channel, code}.
package qdac_pkg;
    // Bit index of the all-channel power-down flag.
    function automatic int pos_glob(input int dw, input int aw);
        return dw + aw + 1;
    endfunction
    // Bit index of the single-channel power-down flag.
    function automatic int pos_one(input int dw, input int aw);
        return dw + aw;
    endfunction
endpackage

// File: rtl/qdac_sync.sv
// Module: qdac_sync
// Brings W asynchronous bits into clk_sys with STAGES flops each, and gives
// the synchronised level plus one-cycle rise and fall pulses.
// Assumes: each input stays stable for at least two clk_sys cycles.
module qdac_sync #(
    parameter int W      = 1,
    parameter int STAGES = 2,
    parameter logic [W-1:0] IDLE = '1
) (
    input  logic         clk_sys,
    input  logic         rst_n,
    input  logic [W-1:0] async_in,
    output logic [W-1:0] lvl,
    output logic [W-1:0] rise,
    output logic [W-1:0] fall
);
    logic [W-1:0] chain [STAGES];
    logic [W-1:0] last;

    // Shift each bit through the synchroniser chain and keep one more copy for edges.
    always_ff @(posedge clk_sys) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) chain[i] <= IDLE;
            last <= IDLE;
        end else begin
            chain[0] <= async_in;
            for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
            last <= chain[STAGES-1];
        end
    end

    assign lvl  = chain[STAGES-1];
    assign rise = chain[STAGES-1] & ~last;
    assign fall = ~chain[STAGES-1] & last;
endmodule

// File: rtl/qdac_shifter.sv
// Module: qdac_shifter
// Collects serial bits MSB first while the frame is low. It counts them and
// pulses word_stb on frame release only when exactly WORD_W bits arrived.
// Assumes: synchronised level/edge inputs from qdac_sync.
module qdac_shifter #(
    parameter int WORD_W = 12
) (
    input  logic              clk_sys,
    input  logic              rst_n,
    input  logic              frame_lvl_n,
    input  logic              frame_rise,
    input  logic              frame_fall,
    input  logic              bclk_rise,
    input  logic              bit_lvl,
    output logic              word_stb,
    output logic [WORD_W-1:0] word
);
    localparam int CNT_W = $clog2(WORD_W + 2);
    localparam logic [CNT_W-1:0] CNT_MAX  = CNT_W'(WORD_W + 1);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(WORD_W);

    logic [WORD_W-1:0] shreg;
    logic [CNT_W-1:0]  cnt;

    // Shift one bit per serial clock rise inside a frame; count up, saturating past full.
    always_ff @(posedge clk_sys) begin
        if (!rst_n) begin
            shreg <= '0;
            cnt   <= '0;
        end else if (frame_fall) begin
            cnt <= '0;
        end else if (!frame_lvl_n && bclk_rise) begin
            shreg <= {shreg[WORD_W-2:0], bit_lvl};
            if (cnt != CNT_MAX) cnt <= cnt + 1'b1;
        end
    end

    // Accept the word only on a frame release with the exact bit count.
    always_ff @(posedge clk_sys) begin
        if (!rst_n) word_stb <= 1'b0;
        else        word_stb <= frame_rise && (cnt == CNT_FULL);
    end

    assign word = shreg;

    a_r4_count_range: assert property (@(posedge clk_sys) disable iff (!rst_n)
        cnt <= CNT_MAX);
    a_r2_idle_clock: assert property (@(posedge clk_sys) disable iff (!rst_n)
        (frame_lvl_n && !frame_fall) |=> $stable(shreg));
    a_r3_strobe_single: assert property (@(posedge clk_sys) disable iff (!rst_n)
        word_stb |=> !word_stb);
endmodule

// File: rtl/qdac_regbank.sv
// Module: qdac_regbank
// Holds the staging and output code registers and the power-down state for
// N_CH channels. Zero wins over command load and transfer.
// Assumes: word_stb is a one-cycle pulse with word fields valid in that cycle.
module qdac_regbank #(
    parameter int N_CH   = 4,
    parameter int DATA_W = 8,
    parameter int ADDR_W = 2
) (
    input  logic                     clk_sys,
    input  logic                     rst_n,
    input  logic                     word_stb,
    input  logic                     glob_off_n,
    input  logic                     one_off_n,
    input  logic [ADDR_W-1:0]        chan,
    input  logic [DATA_W-1:0]        code,
    input  logic                     xfer_lvl_n,
    input  logic                     zero_lvl_n,
    output logic [N_CH*DATA_W-1:0]   dac_code,
    output logic [N_CH-1:0]          chan_off
);
    logic [DATA_W-1:0] stage_q [N_CH];
    logic [DATA_W-1:0] out_q   [N_CH];
    logic [N_CH-1:0]   local_off;
    logic              glob_off;

    // Global power-down follows the all-channel bit of every accepted word.
    always_ff @(posedge clk_sys) begin
        if (!rst_n)        glob_off <= 1'b0;
        else if (word_stb) glob_off <= ~glob_off_n;
    end

    for (genvar c = 0; c < N_CH; c++) begin : g_ch
        logic hit;
        assign hit = word_stb && (chan == ADDR_W'(c));

        // Staging register: cleared by zero, else loaded by an addressed word.
        always_ff @(posedge clk_sys) begin
            if (!rst_n || !zero_lvl_n) stage_q[c] <= '0;
            else if (hit)              stage_q[c] <= code;
        end

        // Output register: cleared by zero, else follows staging while transfer is low.
        always_ff @(posedge clk_sys) begin
            if (!rst_n || !zero_lvl_n) out_q[c] <= '0;
            else if (!xfer_lvl_n)      out_q[c] <= stage_q[c];
        end

        // Per-channel power-down: set by single bit low, cleared by a word with both bits high.
        always_ff @(posedge clk_sys) begin
            if (!rst_n)                           local_off[c] <= 1'b0;
            else if (hit && !one_off_n)           local_off[c] <= 1'b1;
            else if (hit && glob_off_n)           local_off[c] <= 1'b0;
        end

        assign dac_code[c*DATA_W +: DATA_W] = out_q[c];
        assign chan_off[c] = local_off[c] | glob_off;

        a_r5_transfer: assert property (@(posedge clk_sys) disable iff (!rst_n)
            (!xfer_lvl_n && zero_lvl_n) |=> out_q[c] == $past(stage_q[c]));
        a_r5_hold: assert property (@(posedge clk_sys) disable iff (!rst_n)
            (xfer_lvl_n && zero_lvl_n) |=> $stable(out_q[c]));
        a_r6_zero: assert property (@(posedge clk_sys) disable iff (!rst_n)
            !zero_lvl_n |=> (stage_q[c] == '0 && out_q[c] == '0));
        a_r4_no_load: assert property (@(posedge clk_sys) disable iff (!rst_n)
            (zero_lvl_n && !word_stb) |=> $stable(stage_q[c]));
        a_r8_single_off: assert property (@(posedge clk_sys) disable iff (!rst_n)
            (hit && !one_off_n) |=> chan_off[c]);
    end

    a_r7_global_off: assert property (@(posedge clk_sys) disable iff (!rst_n)
        (word_stb && !glob_off_n) |=> (&chan_off));
    a_r9_flags_quiet: assert property (@(posedge clk_sys) disable iff (!rst_n)
        !word_stb |=> $stable(chan_off));
endmodule

// File: rtl/qdac_front.sv
// Module: qdac_front (top)
// Digital front end of a four-channel DAC. It synchronises the host inputs,
// assembles the serial command, and drives the code and power-down registers.
// Assumes: bit_clk at most one quarter of clk_sys, each phase >= 2 cycles.
module qdac_front
    import qdac_pkg::*;
#(
    parameter int N_CH   = 4,
    parameter int DATA_W = 8,
    parameter int SYNC_N = 2
) (
    input  logic                   clk_sys,
    input  logic                   rst_n,
    input  logic                   frame_n,
    input  logic                   bit_clk,
    input  logic                   bit_in,
    input  logic                   xfer_n,
    input  logic                   zero_n,
    output logic [N_CH*DATA_W-1:0] dac_code,
    output logic [N_CH-1:0]        chan_off
);
    localparam int ADDR_W = $clog2(N_CH);
    localparam int WORD_W = DATA_W + ADDR_W + 2;
    localparam int P_GLOB = pos_glob(DATA_W, ADDR_W);
    localparam int P_ONE  = pos_one(DATA_W, ADDR_W);

    logic [4:0] raw, lvl, rise, fall;
    logic              word_stb;
    logic [WORD_W-1:0] word;

    assign raw = {zero_n, xfer_n, bit_in, bit_clk, frame_n};

    qdac_sync #(.W(5), .STAGES(SYNC_N), .IDLE(5'b11001)) u_sync (
        .clk_sys (clk_sys),
        .rst_n   (rst_n),
        .async_in(raw),
        .lvl     (lvl),
        .rise    (rise),
        .fall    (fall)
    );

    qdac_shifter #(.WORD_W(WORD_W)) u_shift (
        .clk_sys    (clk_sys),
        .rst_n      (rst_n),
        .frame_lvl_n(lvl[0]),
        .frame_rise (rise[0]),
        .frame_fall (fall[0]),
        .bclk_rise  (rise[1]),
        .bit_lvl    (lvl[2]),
        .word_stb   (word_stb),
        .word       (word)
    );

    qdac_regbank #(.N_CH(N_CH), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_bank (
        .clk_sys   (clk_sys),
        .rst_n     (rst_n),
        .word_stb  (word_stb),
        .glob_off_n(word[P_GLOB]),
        .one_off_n (word[P_ONE]),
        .chan      (word[DATA_W +: ADDR_W]),
        .code      (word[DATA_W-1:0]),
        .xfer_lvl_n(lvl[3]),
        .zero_lvl_n(lvl[4]),
        .dac_code  (dac_code),
        .chan_off  (chan_off)
    );

    a_r1_reset_clear: assert property (@(posedge clk_sys)
        !rst_n |=> (dac_code == '0 && chan_off == '0));
endmodule

// File: tb/qdac_front_test.sv
module qdac_front_test;
    logic clk_sys = 1'b0;
    logic rst_n = 1'b0;
    logic frame_n = 1'b1, bit_clk = 1'b0, bit_in = 1'b0;
    logic xfer_n = 1'b1, zero_n = 1'b1;
    logic [31:0] dac_code;
    logic [3:0]  chan_off;
    int total = 0, bad = 0;
    bit done = 0;

    always #10 clk_sys = ~clk_sys;

    qdac_front uut (.clk_sys(clk_sys), .rst_n(rst_n), .frame_n(frame_n),
        .bit_clk(bit_clk), .bit_in(bit_in), .xfer_n(xfer_n), .zero_n(zero_n),
        .dac_code(dac_code), .chan_off(chan_off));

    // word[11:0], bit count, expected codes {ch3,ch2,ch1,ch0}, expected flags
    localparam int NV = 11;
    localparam logic [51:0] VEC [NV] = '{
        {12'b11_00_00111100, 4'd12, 32'h00_00_00_3C, 4'b0000}, // R3 ch0
        {12'b11_01_10100101, 4'd12, 32'h00_00_A5_3C, 4'b0000}, // R3 ch1
        {12'b11_10_11111111, 4'd12, 32'h00_FF_A5_3C, 4'b0000}, // R3 ch2
        {12'b11_11_00000001, 4'd12, 32'h01_FF_A5_3C, 4'b0000}, // R3 ch3
        {12'b10_10_01000100, 4'd12, 32'h01_44_A5_3C, 4'b0100}, // R8 set
        {12'b01_00_01110111, 4'd12, 32'h01_44_A5_77, 4'b1111}, // R7 set
        {12'b11_01_01011010, 4'd12, 32'h01_44_5A_77, 4'b0100}, // R7 release
        {12'b11_10_01000100, 4'd12, 32'h01_44_5A_77, 4'b0000}, // R8 release, R9
        {12'b11_11_10011001, 4'd11, 32'h01_44_5A_77, 4'b0000}, // R4 short
        {12'b11_11_10011001, 4'd13, 32'h01_44_5A_77, 4'b0000}, // R4 long
        {12'b11_11_10011001, 4'd12, 32'h99_44_5A_77, 4'b0000}  // R2 MSB first
    };

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk_sys);
    endtask

    task automatic send(input logic [11:0] w, input int nb);
        frame_n = 1'b0; wait_n(3);
        for (int i = 0; i < nb; i++) begin
            bit_in = (i < 12) ? w[11-i] : 1'b0;
            wait_n(3); bit_clk = 1'b1; wait_n(3); bit_clk = 1'b0;
        end
        wait_n(3); frame_n = 1'b1; wait_n(6);
    endtask

    task automatic pulse_xfer();
        xfer_n = 1'b0; wait_n(6); xfer_n = 1'b1; wait_n(4);
    endtask

    task automatic check(input string req, input logic [31:0] ec, input logic [3:0] ef);
        total++;
        if (dac_code !== ec || chan_off !== ef) begin
            bad++;
            $display("FAIL %s: code=%h flags=%b expected code=%h flags=%b",
                     req, dac_code, chan_off, ec, ef);
        end
    endtask

    initial begin
        wait_n(3); rst_n = 1'b1; wait_n(3);
        check("R1 reset", 32'h0, 4'b0);
        for (int v = 0; v < NV; v++) begin
            send(VEC[v][51:40], int'(VEC[v][39:36]));
            pulse_xfer();
            check("R2/R3/R4/R7/R8 vector", VEC[v][35:4], VEC[v][3:0]);
        end
        // R5: transfer held high keeps outputs
        send(12'b11_00_00010010, 12);
        check("R5 hold", 32'h99_44_5A_77, 4'b0);
        pulse_xfer();
        check("R5 transfer", 32'h99_44_5A_12, 4'b0);
        // R2: serial clock with frame high ignored
        for (int i = 0; i < 12; i++) begin
            bit_in = 1'b1; wait_n(3); bit_clk = 1'b1; wait_n(3); bit_clk = 1'b0;
        end
        wait_n(4); pulse_xfer();
        check("R2 idle clock", 32'h99_44_5A_12, 4'b0);
        // R9: power-down keeps code
        send(12'b10_01_00110011, 12); pulse_xfer();
        check("R9 code kept", 32'h99_44_33_12, 4'b0010);
        // R6: zero wins over command and transfer
        zero_n = 1'b0; wait_n(6);
        check("R6 zero low", 32'h0, 4'b0010);
        send(12'b11_11_11110000, 12);
        xfer_n = 1'b0; wait_n(6); xfer_n = 1'b1; wait_n(4);
        check("R6 priority", 32'h0, 4'b0010);
        zero_n = 1'b1; wait_n(6); pulse_xfer();
        check("R6 stays zero", 32'h0, 4'b0010);
        send(12'b11_01_00001111, 12); pulse_xfer();
        check("R8 clear after zero", 32'h00_00_0F_00, 4'b0000);
        // R1: reset mid-run
        rst_n = 1'b0; wait_n(2); rst_n = 1'b1; wait_n(4);
        check("R1 reset again", 32'h0, 4'b0);
        done = 1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (100000) @(posedge clk_sys);
                total++; bad++;
                $display("FAIL watchdog: run did not finish, actual=hung expected=done");
            end
        join_any
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule